// File: doc/BRIEF.md
# Overcurrent Limit and Frequency Foldback Controller

This block sits between the primary-side current comparators and the PWM sequencer of an isolated half-bridge converter. It keeps a digital limit level that stands in for the analog integrating capacitor of a current-limit loop. From that level it derives a ceiling on the duty cycle and a stretch factor for the switching period. The sequencer applies both, together with a hard stop flag for the primary drives.

The level is held in a saturating counter. Two comparator flags tell the block whether the sensed current is above a lower threshold or above an upper threshold, and a 2-bit magnitude code grades how far past the lower threshold it is. On each switching-period strobe the level climbs slowly when there is no overcurrent, or falls by a magnitude-dependent step in the moderate band. The upper-threshold flag snaps it to its floor at once, on any cycle.

As the level sinks, the duty ceiling shrinks first. Only once the ceiling sits at its floor does the period start to stretch, up to five times nominal. When the current recovers, the level simply climbs back with no soft-start replay. Duty is expressed in 1/256 units of the period and the period stretch in quarter-period units (4 means nominal).

Top module: `ocp_foldback`

## Requirements
- R1: While reset is applied and after it is released, the outputs show the top level 255: duty_cap = 235, period_scale = 4, drive_off = 0, mode = 2'b00.
- R2: On a cycle with period_tick = 1, sense_lo = 0 and sense_hi = 0, the level rises by 2, saturating at 255.
- R3: On a cycle with period_tick = 1, sense_lo = 1 and sense_hi = 0, the level falls by 4 × (sense_mag + 1), that is 4, 8, 12 or 16 for codes 0 to 3, saturating at the floor 16.
- R4: A cycle with sense_hi = 1, with or without period_tick, sets the level to 16 and raises drive_off with mode = 2'b11 on the following cycle. The upper flag takes priority over every other input.
- R5: On a cycle with period_tick = 0 and sense_hi = 0, the level is unchanged whatever sense_lo and sense_mag are.
- R6: For a level L in 80..207, mode = 2'b01, period_scale = 4 and duty_cap = 8 + floor((L − 80) × 227 / 128).
- R7: For a level L below 80, mode = 2'b10, duty_cap = 8 and period_scale = 4 + floor((80 − L) / 4), reaching 20 (five times the nominal period) at the floor.
- R8: For a level of 208 or more, mode = 2'b00, duty_cap = 235 and period_scale = 4.
- R9: The first cycle without sense_hi clears drive_off. Level recovery from the floor starts on the next tick without overcurrent, with no restart delay.
- R10: duty_cap never goes below 8, which sets the minimum on-time, and never goes above 235. period_scale stays within 4..20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_tick | input | 1 | One-cycle strobe per switching period |
| sense_lo | input | 1 | Current above the lower threshold |
| sense_hi | input | 1 | Current above the upper threshold |
| sense_mag | input | 2 | Overcurrent magnitude code in the moderate band |
| duty_cap | output | 8 | Duty ceiling in 1/256 of the period |
| period_scale | output | 5 | Period multiplier in quarter units (4 = nominal) |
| drive_off | output | 1 | Disable both primary drives |
| mode | output | 2 | 00 normal, 01 duty limiting, 10 foldback, 11 stopped |

## Verification
The assertions assume that period_tick is a single-cycle strobe and that sense_mag is only meaningful while sense_lo is high. They also assume that sense_hi may arrive on any cycle, independent of the strobe. The stimulus changes inputs only at falling edges and returns every input to idle after one rising edge, so each strobe is seen exactly once. The stimulus also raises sense_hi both alone and together with a strobe and the lower flag, to exercise the priority.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OCP_RUN  = 2'b00,
    OCP_TRIM = 2'b01,
    OCP_FOLD = 2'b10,
    OCP_HALT = 2'b11
  } ocp_mode_t;
endpackage

// File: rtl/ocp_level.sv
module ocp_level #(
  parameter int LW      = 8,
  parameter int LVL_MAX = 255,
  parameter int LVL_MIN = 16,
  parameter int UP_STEP = 2,
  parameter int DN_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          above_lo,
  input  logic          above_hi,
  input  logic [1:0]    mag,
  output logic [LW-1:0] level,
  output logic          halt
);
  logic [LW-1:0] level_q, level_d;
  logic          halt_q;
  logic          level_en;
  logic [LW:0]   rate, up_val, dn_val;

  assign level_en = above_hi | tick;

  always_comb begin
    rate   = (LW+1)'(DN_STEP * (int'(mag) + 1));
    up_val = {1'b0, level_q} + (LW+1)'(UP_STEP);
    dn_val = {1'b0, level_q} - rate;
    if (above_hi) begin
      level_d = LW'(LVL_MIN);
    end else if (above_lo) begin
      if (dn_val[LW] || (dn_val < (LW+1)'(LVL_MIN)))
        level_d = LW'(LVL_MIN);
      else
        level_d = dn_val[LW-1:0];
    end else begin
      if (up_val > (LW+1)'(LVL_MAX))
        level_d = LW'(LVL_MAX);
      else
        level_d = up_val[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LW'(LVL_MAX);
      halt_q  <= 1'b0;
    end else begin
      if (level_en) level_q <= level_d;
      halt_q <= above_hi;
    end
  end

  assign level = level_q;
  assign halt  = halt_q;

  // R3 / R2: level stays inside its clamps
  a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q >= LW'(LVL_MIN)) && (level_q <= LW'(LVL_MAX)));
  a_r4_trip_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    above_hi |=> (level_q == LW'(LVL_MIN)) && halt_q);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_hi && !tick) |=> $stable(level_q));
  a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !above_lo && !above_hi) |=> (level_q >= $past(level_q)));
  a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && above_lo && !above_hi) |=> (level_q <= $past(level_q)));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !above_hi |=> !halt_q);
endmodule

// File: rtl/ocp_duty_map.sv
module ocp_duty_map #(
  parameter int LW         = 8,
  parameter int DW         = 8,
  parameter int FOLD_KNEE  = 80,
  parameter int DUTY_SHIFT = 7,
  parameter int DUTY_MIN   = 8,
  parameter int DUTY_MAX   = 235
) (
  input  logic [LW-1:0] level,
  output logic [DW-1:0] duty
);
  localparam int DUTY_KNEE = FOLD_KNEE + (1 << DUTY_SHIFT);
  localparam int PW        = LW + DW;

  logic [LW-1:0] off;
  logic [PW-1:0] prod;

  always_comb begin
    off  = level - LW'(FOLD_KNEE);
    prod = PW'(off) * PW'(DUTY_MAX - DUTY_MIN);
    if (level >= LW'(DUTY_KNEE))
      duty = DW'(DUTY_MAX);
    else if (level < LW'(FOLD_KNEE))
      duty = DW'(DUTY_MIN);
    else
      duty = DW'(DUTY_MIN) + DW'(prod >> DUTY_SHIFT);
  end
endmodule

// File: rtl/ocp_fold_map.sv
module ocp_fold_map #(
  parameter int LW         = 8,
  parameter int SW         = 5,
  parameter int FOLD_KNEE  = 80,
  parameter int FOLD_SHIFT = 2
) (
  input  logic [LW-1:0] level,
  output logic [SW-1:0] scale
);
  localparam int STEPS = 16;

  logic [LW-1:0] diff, step;

  always_comb begin
    diff = LW'(FOLD_KNEE) - level;
    step = diff >> FOLD_SHIFT;
    if (level >= LW'(FOLD_KNEE))
      scale = SW'(4);
    else if (step > LW'(STEPS))
      scale = SW'(4 + STEPS);
    else
      scale = SW'(4) + SW'(step);
  end
endmodule

// File: rtl/ocp_foldback.sv
module ocp_foldback #(
  parameter int LW         = 8,
  parameter int DW         = 8,
  parameter int FOLD_KNEE  = 80,
  parameter int FOLD_SHIFT = 2,
  parameter int DUTY_SHIFT = 7,
  parameter int DUTY_MIN   = 8,
  parameter int DUTY_MAX   = 235,
  parameter int UP_STEP    = 2,
  parameter int DN_STEP    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_tick,
  input  logic          sense_lo,
  input  logic          sense_hi,
  input  logic [1:0]    sense_mag,
  output logic [DW-1:0] duty_cap,
  output logic [4:0]    period_scale,
  output logic          drive_off,
  output logic [1:0]    mode
);
  import ocp_pkg::*;

  localparam int LVL_MAX   = (1 << LW) - 1;
  localparam int LVL_MIN   = FOLD_KNEE - (16 << FOLD_SHIFT);
  localparam int DUTY_KNEE = FOLD_KNEE + (1 << DUTY_SHIFT);
  localparam int SW        = 5;

  logic [1:0]    rst_sync;
  logic          rst_sn;
  logic [LW-1:0] level;
  logic          halt;
  ocp_mode_t     mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  ocp_level #(
    .LW(LW), .LVL_MAX(LVL_MAX), .LVL_MIN(LVL_MIN),
    .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)
  ) u_level (
    .clk(clk), .rst_n(rst_sn), .tick(period_tick),
    .above_lo(sense_lo), .above_hi(sense_hi), .mag(sense_mag),
    .level(level), .halt(halt)
  );

  ocp_duty_map #(
    .LW(LW), .DW(DW), .FOLD_KNEE(FOLD_KNEE), .DUTY_SHIFT(DUTY_SHIFT),
    .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) u_duty (
    .level(level), .duty(duty_cap)
  );

  ocp_fold_map #(
    .LW(LW), .SW(SW), .FOLD_KNEE(FOLD_KNEE), .FOLD_SHIFT(FOLD_SHIFT)
  ) u_fold (
    .level(level), .scale(period_scale)
  );

  always_comb begin
    if (halt)                         mode_w = OCP_HALT;
    else if (level < LW'(FOLD_KNEE))  mode_w = OCP_FOLD;
    else if (level < LW'(DUTY_KNEE))  mode_w = OCP_TRIM;
    else                              mode_w = OCP_RUN;
  end

  assign mode      = mode_w;
  assign drive_off = halt;

  // R10: duty ceiling and period stretch stay in range
  a_r10_duty_bounds: assert property (@(posedge clk) disable iff (!rst_sn)
    (duty_cap >= DW'(DUTY_MIN)) && (duty_cap <= DW'(DUTY_MAX)));
  a_r10_scale_bounds: assert property (@(posedge clk) disable iff (!rst_sn)
    (period_scale >= 5'd4) && (period_scale <= 5'd20));
  a_r7_fold_after_duty: assert property (@(posedge clk) disable iff (!rst_sn)
    (period_scale != 5'd4) |-> (duty_cap == DW'(DUTY_MIN)));
  a_r6_no_stretch_above_knee: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_w == OCP_TRIM || mode_w == OCP_RUN) |-> (period_scale == 5'd4));
  a_r4_halt_mode: assert property (@(posedge clk) disable iff (!rst_sn)
    drive_off |-> (mode == 2'b11));
endmodule

// File: tb/sim_ocp_foldback.sv
`timescale 1ns/1ps
module sim_ocp_foldback;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       period_tick, sense_lo, sense_hi;
  logic [1:0] sense_mag;
  logic [7:0] duty_cap;
  logic [4:0] period_scale;
  logic       drive_off;
  logic [1:0] mode;

  int errors = 0;
  int checks = 0;
  int lvl;
  bit halt_m;

  always #2 clk = ~clk;

  ocp_foldback u0 (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
    .sense_lo(sense_lo), .sense_hi(sense_hi), .sense_mag(sense_mag),
    .duty_cap(duty_cap), .period_scale(period_scale),
    .drive_off(drive_off), .mode(mode)
  );

  function automatic int exp_duty(int l);
    if (l >= 208) return 235;
    if (l < 80) return 8;
    return 8 + ((l - 80) * 227) / 128;
  endfunction

  function automatic int exp_scale(int l);
    int s;
    if (l >= 80) return 4;
    s = (80 - l) / 4;
    if (s > 16) s = 16;
    return 4 + s;
  endfunction

  function automatic int exp_mode(int l, bit h);
    if (h) return 3;
    if (l < 80) return 2;
    if (l < 208) return 1;
    return 0;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "duty_cap", int'(duty_cap), exp_duty(lvl));
    chk(req, "period_scale", int'(period_scale), exp_scale(lvl));
    chk(req, "drive_off", int'(drive_off), int'(halt_m));
    chk(req, "mode", int'(mode), exp_mode(lvl, halt_m));
  endtask

  // called at a falling edge; applies inputs for exactly one rising edge
  task automatic step(bit tk, bit lo, bit hi, int mg, string req);
    period_tick = tk; sense_lo = lo; sense_hi = hi; sense_mag = 2'(mg);
    @(negedge clk);
    period_tick = 0; sense_lo = 0; sense_hi = 0; sense_mag = 0;
    halt_m = hi;
    if (hi) lvl = 16;
    else if (tk) begin
      if (lo) begin
        lvl = lvl - 4 * (mg + 1);
        if (lvl < 16) lvl = 16;
      end else begin
        lvl = lvl + 2;
        if (lvl > 255) lvl = 255;
      end
    end
    chk_all(req);
  endtask

  task automatic t_reset;
    rst_n = 0; period_tick = 0; sense_lo = 0; sense_hi = 0; sense_mag = 0;
    lvl = 255; halt_m = 0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_all("R1");
  endtask

  task automatic t_idle_ignored;
    // R5: no strobe, lower flag and magnitude must not move the level
    for (int i = 0; i < 5; i++) step(0, 1, 0, 3, "R5");
    step(1, 1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 2, "R5");
  endtask

  task automatic t_discharge;
    for (int i = 0; i < 4; i++)  step(1, 1, 0, 0, "R3");
    chk_all("R8");
    for (int i = 0; i < 6; i++)  step(1, 1, 0, 1, "R6");
    for (int i = 0; i < 8; i++)  step(1, 1, 0, 2, "R6");
    for (int i = 0; i < 6; i++)  step(1, 1, 0, 3, "R7");
    chk(  "R7", "floor scale", int'(period_scale), 20);
    chk(  "R10", "floor duty", int'(duty_cap), 8);
  endtask

  task automatic t_recover_no_restart;
    step(1, 0, 0, 0, "R9");
    chk("R9", "first recovery duty", int'(duty_cap), 8);
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, "R2");
  endtask

  task automatic t_trip_alone;
    step(0, 0, 1, 0, "R4");
    chk("R4", "drive_off", int'(drive_off), 1);
    step(0, 0, 1, 0, "R4");
    step(0, 0, 0, 0, "R9");
    chk("R9", "drive_off released", int'(drive_off), 0);
  endtask

  task automatic t_recharge_full;
    for (int i = 0; i < 125; i++) step(1, 0, 0, 0, "R2");
    chk("R8", "saturated duty", int'(duty_cap), 235);
    chk("R8", "saturated mode", int'(mode), 0);
  endtask

  task automatic t_trip_priority;
    step(1, 1, 1, 0, "R4");
    chk("R4", "priority scale", int'(period_scale), 20);
    step(1, 0, 0, 0, "R9");
    step(1, 0, 0, 0, "R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_discharge();
    t_recover_no_restart();
    t_trip_alone();
    t_recharge_full();
    t_trip_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule